// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This block steps a clock generator from supply-off to normal running. After the supply comes up it starts the internal oscillator. It then waits in one of two ways. It can wait for a fixed settling interval, or it can wait for an active-low power-good signal to fall, followed by a short qualification delay. Next it captures the four frequency-select straps once, lets a second delay elapse, and only then enables the clock outputs.

The asynchronous reset stands for loss of supply. It drops the machine back to the off state, clears the captured straps and makes the power-good input eligible again. A mode input chooses the wait style. It is captured during the off state, so it takes effect once per power-up. Every interval is a cycle count taken from a reference-clock frequency parameter, and each count can be overridden.

Top module: `clkgen_pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0 (off), `sel_o` is 0, and `osc_en_o` and `out_en_o` are 0.
- R2: The state code on `state_o` is 0 = off, 1 = wait, 2 = sample, 3 = run. The states only advance in that order. Off lasts exactly one cycle after reset release, and `mode_pg_i` is captured in that cycle (1 = power-good wait, 0 = fixed wait).
- R3: In fixed-wait mode the wait state lasts exactly `WAIT_CYC` cycles.
- R4: In power-good mode the wait state holds until an accepted falling edge of `pgood_ni`. The sample state is entered exactly `PG_DLY_CYC` + 3 cycles after the input falls (two synchronizer stages plus one qualification flop).
- R5: Only the first accepted falling edge of `pgood_ni` after reset has any effect. Later rises and falls neither restart the delay nor change the state.
- R6: `fsel_i` is captured into `sel_o` on the clock edge that enters the sample state. `sel_o` then holds that value for the rest of operation, whatever `fsel_i` does.
- R7: The sample state lasts exactly `OUT_DLY_CYC` cycles, then the run state is entered and kept until reset.
- R8: `out_en_o` is 1 exactly in the run state. `osc_en_o` is 1 in every state except off.
- R9: Asserting `rst_ni` low from any state returns the outputs at once to the R1 values and re-arms power-good qualification for the next power-up.
- R10: A falling edge counts only if `pgood_ni` was first seen high after reset. An input held low from reset onward leaves the machine in the wait state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset (supply off) |
| mode_pg_i | input | 1 | Wait style: 1 = power-good qualified, 0 = fixed timer |
| pgood_ni | input | 1 | Asynchronous active-low power-good |
| fsel_i | input | SEL_W | Frequency-select straps |
| sel_o | output | SEL_W | Captured frequency select |
| osc_en_o | output | 1 | Internal oscillator enable |
| out_en_o | output | 1 | Clock output enable |
| state_o | output | 2 | Current sequencer state code |

## Verification
Two events can land on the same edge. One is the strap capture. The other is a change of `fsel_i` by the board, or a second power-good edge arriving during the qualification delay. The bench drives a new strap value in the cycle just before the sample state is entered and changes it again right after that edge. The captured value must be the one present at the entry edge. It also toggles `pgood_ni` while the delay counter is running, and checks through the scoreboard that the wait dwell does not change by a single cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_WAIT   = 2'd1,
        PS_SAMPLE = 2'd2,
        PS_RUN    = 2'd3
    } pwrseq_state_e;
endpackage

// File: rtl/pwrseq_sync2.sv
module pwrseq_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {2{RST_VAL}};
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[1];
endmodule

// File: rtl/pwrseq_pg_qual.sv
// Accepts one falling edge of the synchronized active-low power-good and
// remembers it until reset; the flag doubles as the disarm indication.
module pwrseq_pg_qual (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pg_n_i,
    output logic hit_o
);
    typedef struct packed {
        logic prev;
        logic hit;
    } qual_t;

    qual_t q_d, q_q;

    always_comb begin
        q_d      = q_q;
        q_d.prev = pg_n_i;
        if (!q_q.hit && q_q.prev && !pg_n_i) q_d.hit = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    assign hit_o = q_q.hit;
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [CW-1:0] lim_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)     cnt_d = '0;
        else if (en_i) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = en_i && (cnt_q == lim_i - CW'(1));
endmodule

// File: rtl/clkgen_pwrup_seq.sv
module clkgen_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned REF_HZ      = 25_000_000,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned WAIT_CYC    = (REF_HZ / 1000) * 1146 / 1000,
    parameter int unsigned PG_DLY_CYC  = REF_HZ / 4000,
    parameter int unsigned OUT_DLY_CYC = REF_HZ / 4000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_pg_i,
    input  logic             pgood_ni,
    input  logic [SEL_W-1:0] fsel_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             osc_en_o,
    output logic             out_en_o,
    output logic [1:0]       state_o
);
    localparam int unsigned MAX_A   = (WAIT_CYC > PG_DLY_CYC) ? WAIT_CYC : PG_DLY_CYC;
    localparam int unsigned CNT_MAX = (MAX_A > OUT_DLY_CYC) ? MAX_A : OUT_DLY_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LIM_WAIT = CW'(WAIT_CYC);
    localparam logic [CW-1:0] LIM_PG   = CW'(PG_DLY_CYC);
    localparam logic [CW-1:0] LIM_OUT  = CW'(OUT_DLY_CYC);

    typedef struct packed {
        pwrseq_state_e    st;
        logic             mode;
        logic [SEL_W-1:0] sel;
        logic             osc;
        logic             oe;
    } seq_t;

    seq_t r_d, r_q;

    logic          pg_s;
    logic          pg_hit;
    logic          tmr_clr;
    logic          tmr_en;
    logic [CW-1:0] tmr_lim;
    logic          tmr_done;

    pwrseq_sync2 #(.RST_VAL(1'b0)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pgood_ni),
        .q_o    (pg_s)
    );

    pwrseq_pg_qual u_qual (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pg_n_i (pg_s),
        .hit_o  (pg_hit)
    );

    pwrseq_timer #(.CW(CW)) u_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tmr_clr),
        .en_i   (tmr_en),
        .lim_i  (tmr_lim),
        .done_o (tmr_done)
    );

    always_comb begin
        r_d     = r_q;
        tmr_clr = 1'b0;
        tmr_en  = 1'b0;
        tmr_lim = LIM_WAIT;
        unique case (r_q.st)
            PS_OFF: begin
                r_d.st   = PS_WAIT;
                r_d.mode = mode_pg_i;
                tmr_clr  = 1'b1;
            end
            PS_WAIT: begin
                if (r_q.mode) begin
                    tmr_lim = LIM_PG;
                    tmr_en  = pg_hit;
                end else begin
                    tmr_en  = 1'b1;
                end
                if (tmr_done) begin
                    r_d.st  = PS_SAMPLE;
                    r_d.sel = fsel_i;
                    tmr_clr = 1'b1;
                end
            end
            PS_SAMPLE: begin
                tmr_lim = LIM_OUT;
                tmr_en  = 1'b1;
                if (tmr_done) begin
                    r_d.st  = PS_RUN;
                    tmr_clr = 1'b1;
                end
            end
            default: begin
                r_d.st = PS_RUN;
            end
        endcase
        r_d.osc = (r_d.st != PS_OFF);
        r_d.oe  = (r_d.st == PS_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: PS_OFF, mode: 1'b0, sel: '0, osc: 1'b0, oe: 1'b0};
        else         r_q <= r_d;
    end

    assign sel_o    = r_q.sel;
    assign osc_en_o = r_q.osc;
    assign out_en_o = r_q.oe;
    assign state_o  = r_q.st;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
    parameter int unsigned SEL_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       state_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             osc_en_i,
    input logic             out_en_i
);
    // R2: off is left after one cycle, and only for wait
    p_off_to_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == 2'd0) |=> (state_i == 2'd1));

    // R2: any change of state is a single step forward
    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i != $past(state_i)) |-> (state_i == $past(state_i) + 2'd1));

    // R7: run is kept until reset
    p_run_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == 2'd3) |=> (state_i == 2'd3));

    // R6: captured select never moves after sampling is over
    p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == 2'd3 && $past(state_i) >= 2'd2) |-> $stable(sel_i));

    // R8: enables agree with the state code
    p_out_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_en_i == (state_i == 2'd3));
    p_osc_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_en_i == (state_i != 2'd0));
endmodule

bind clkgen_pwrup_seq pwrseq_chk #(.SEL_W(SEL_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state_o),
    .sel_i    (sel_o),
    .osc_en_i (osc_en_o),
    .out_en_i (out_en_o)
);

// File: tb/test_clkgen_pwrup_seq.sv
module test_clkgen_pwrup_seq;
    localparam int WC = 20;
    localparam int PC = 7;
    localparam int OC = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_pg;
    logic       pgood_n;
    logic [3:0] fsel;
    logic [3:0] sel;
    logic       osc_en;
    logic       out_en;
    logic [1:0] state;

    clkgen_pwrup_seq #(
        .REF_HZ(1_000_000), .SEL_W(4),
        .WAIT_CYC(WC), .PG_DLY_CYC(PC), .OUT_DLY_CYC(OC)
    ) i_clkgen_pwrup_seq (
        .clk_i(clk), .rst_ni(rst_n), .mode_pg_i(mode_pg), .pgood_ni(pgood_n),
        .fsel_i(fsel), .sel_o(sel), .osc_en_o(osc_en), .out_en_o(out_en),
        .state_o(state)
    );

    always #5 clk = ~clk;

    typedef struct { int st; int dwell; string tag; } exp_t;
    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int last = 0;
    int dwell = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Monitor: measures how long each state lasts and pops the expectation
    always @(negedge clk) begin
        if (!rst_n) begin
            last  = 0;
            dwell = 0;
        end else if (int'(state) == last) begin
            dwell++;
        end else begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected transition", last, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(last == e.st, "R2 state order", last, e.st);
                chk(dwell == e.dwell, e.tag, dwell, e.dwell);
            end
            chk(osc_en == (state != 2'd0), "R8 osc_en", int'(osc_en), int'(state != 2'd0));
            chk(out_en == (state == 2'd3), "R8 out_en", int'(out_en), int'(state == 2'd3));
            last  = int'(state);
            dwell = 1;
        end
    end

    task automatic push(input int st, input int d, input string tag);
        exp_t e;
        e.st = st; e.dwell = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_pg = 1'b0; pgood_n = 1'b1; fsel = 4'h5;
        tick(3);
        chk(state == 2'd0, "R1 state", int'(state), 0);
        chk(sel == 4'h0, "R1 sel", int'(sel), 0);
        chk(osc_en == 1'b0, "R1 osc_en", int'(osc_en), 0);
        chk(out_en == 1'b0, "R1 out_en", int'(out_en), 0);

        // Run A: fixed wait
        push(0, 1, "R2 off dwell");
        push(1, WC, "R3 fixed wait dwell");
        push(2, OC, "R7 sample dwell");
        @(posedge clk); #2; rst_n = 1'b1;
        tick(WC);
        fsel = 4'hA;               // present on the edge that enters sample
        tick(1);
        fsel = 4'h3;               // changed right after capture
        tick(OC + 5);
        chk(state == 2'd3, "R7 run reached", int'(state), 3);
        chk(sel == 4'hA, "R6 captured select", int'(sel), 10);
        chk(out_en == 1'b1, "R8 out_en in run", int'(out_en), 1);
        chk(exp_q.size() == 0, "R7 all transitions seen", exp_q.size(), 0);
        fsel = 4'hC;
        tick(3);
        chk(sel == 4'hA, "R6 select held", int'(sel), 10);
        pgood_n = 1'b0;
        tick(5);
        chk(state == 2'd3, "R5 late fall ignored", int'(state), 3);

        // R9: supply loss from run
        rst_n = 1'b0;
        #1;
        chk(state == 2'd0, "R9 state", int'(state), 0);
        chk(sel == 4'h0, "R9 sel cleared", int'(sel), 0);
        chk(osc_en == 1'b0, "R9 osc_en", int'(osc_en), 0);
        chk(out_en == 1'b0, "R9 out_en", int'(out_en), 0);

        // Run B: power-good wait, input held low from reset
        mode_pg = 1'b1; pgood_n = 1'b0; fsel = 4'h6;
        tick(2);
        push(0, 1, "R2 off dwell");
        push(1, 34 + 2 + PC, "R4 power-good wait dwell");
        push(2, OC, "R7 sample dwell");
        @(posedge clk); #2; rst_n = 1'b1;
        tick(30);
        chk(state == 2'd1, "R10 held-low input not accepted", int'(state), 1);
        pgood_n = 1'b1;
        tick(4);
        pgood_n = 1'b0;            // accepted fall, after edge 34
        tick(4);
        pgood_n = 1'b1;            // second pulse during the delay
        tick(1);
        pgood_n = 1'b0;
        tick(5);
        fsel = 4'h9;               // after the capture edge 44
        tick(OC + 4);
        chk(state == 2'd3, "R4 run reached", int'(state), 3);
        chk(sel == 4'h6, "R6 captured select run B", int'(sel), 6);
        chk(exp_q.size() == 0, "R5 no extra transitions", exp_q.size(), 0);
        pgood_n = 1'b1;
        tick(3);
        pgood_n = 1'b0;
        tick(5);
        chk(state == 2'd3, "R5 later edges ignored", int'(state), 3);
        chk(sel == 4'h6, "R6 select held run B", int'(sel), 6);

        summary();
        $finish;
    end
endmodule